// File: doc/BRIEF.md
# DRAM Bank Timing Checker

This block watches a DDR2-style command bus without driving it. It samples chip select, RAS, CAS and WE, a two-bit bank address and address bit 10 on every rising clock edge. From these it decodes a command and keeps an open/closed record for each of four banks. Each command is judged against two kinds of rule. One kind is about bank state, for example activating a bank that is already open. The other kind is about minimum spacing between related commands. Any breach sets a sticky flag for that kind of violation.

The spacing limits are elaboration-time cycle counts. A limit of T between two commands means this: if the first command is sampled at edge n and the second at edge m, the pair is legal only when m - n >= T. Read/write data, refresh, mode setting and power states are not observed. The checker is meant to sit beside a memory controller or a bus model in simulation or on silicon debug logic and report misuse as it happens.

Top module: `ddr_bank_checker`

## Requirements
- R1: The command sampled at a rising edge is shown on `cmd_code` right after that same edge, with codes 0 deselect, 1 NOP (cs_n low, ras_n/cas_n/we_n high), 2 activate (cs_n, ras_n low; cas_n, we_n high), 3 read (cs_n, cas_n low; ras_n, we_n high), 4 write (cs_n, cas_n, we_n low; ras_n high), 5 precharge (cs_n, ras_n, we_n low; cas_n high), 6 any other pattern with cs_n low.
- R2: With cs_n high the other bus inputs are ignored: code 0, no bank state change and no flag change.
- R3: There are four banks, chosen by `ba`. An activate opens the addressed bank. A precharge with `a10` high closes every open bank. A precharge with `a10` low closes only bank `ba`. A precharge has no effect on a bank that is already closed.
- R4: An activate to an open bank sets `err_flags[0]`.
- R5: A read or write to a closed bank sets `err_flags[1]`.
- R6: A read or write to an open bank sooner than T_RCD after that bank's activate sets `err_flags[2]`.
- R7: An activate sooner than T_RRD after an activate of a different bank sets `err_flags[3]`.
- R8: An activate sooner than T_RP after the bank was closed by a single-bank or all-bank precharge sets `err_flags[4]`.
- R9: A precharge that closes a bank sooner than T_RAS after that bank's activate sets `err_flags[5]`.
- R10: An activate sooner than T_RC after the previous activate of the same bank sets `err_flags[6]`.
- R11: A precharge that closes a bank sooner than T_WR after a write accepted by that open bank sets `err_flags[7]`.
- R12: Flags are sticky until reset. A flagged command still takes its normal effect on bank state and timers.
- R13: `rst_n` low clears everything at once. After release, commands are observed from the third rising edge onward. After reset, `cmd_code` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank select on precharge) |
| cmd_code | output | 3 | Last decoded command (R1 codes) |
| err_flags | output | 8 | Sticky violation flags (bit meanings in R4 to R11) |

## Verification
Every spacing rule is swept over gaps from one cycle to one past its limit. This shows the exact boundary cycle where a flag starts or stops firing, and so separates off-by-one counters from correct ones. An exhaustive pass over all control-pin patterns, with deselect mixed in, checks the decoder and confirms that a deselected bus leaves state alone. Multi-bank sequences separate single-bank precharge from all-bank precharge, and same-bank spacing from cross-bank spacing. A model in the bench keyed on edge timestamps supplies every expected flag vector.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  typedef enum logic [2:0] {
    CMD_DES   = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_RD    = 3'd3,
    CMD_WR    = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_OTHER = 3'd6
  } cmd_e;

  localparam int ERR_W      = 8;
  localparam int E_ACT_OPEN = 0;
  localparam int E_RW_SHUT  = 1;
  localparam int E_RCD      = 2;
  localparam int E_RRD      = 3;
  localparam int E_RP       = 4;
  localparam int E_RAS      = 5;
  localparam int E_RC       = 6;
  localparam int E_WR       = 7;

endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DES;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_WR  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9,
  parameter int CW    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_hit,
  input  logic wr_hit,
  input  logic pre_hit,
  output logic is_open,
  output logic rcd_ok,
  output logic ras_ok,
  output logic rc_ok,
  output logic rp_ok,
  output logic wr_ok
);

  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_WR  = CW'(T_WR - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);

  logic          open_q, open_d;
  logic [CW-1:0] rcd_q, rcd_d;
  logic [CW-1:0] rp_q, rp_d;
  logic [CW-1:0] wr_q, wr_d;
  logic [CW-1:0] ras_q, ras_d;
  logic [CW-1:0] rc_q, rc_d;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    open_d = open_q;
    rcd_d  = step_down(rcd_q);
    rp_d   = step_down(rp_q);
    wr_d   = step_down(wr_q);
    ras_d  = step_down(ras_q);
    rc_d   = step_down(rc_q);
    if (act_hit) begin
      open_d = 1'b1;
      rcd_d  = LD_RCD;
      ras_d  = LD_RAS;
      rc_d   = LD_RC;
    end
    if (wr_hit && open_q) begin
      wr_d = LD_WR;
    end
    if (pre_hit && open_q) begin
      open_d = 1'b0;
      rp_d   = LD_RP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      rp_q   <= '0;
      wr_q   <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
    end else begin
      open_q <= open_d;
      rcd_q  <= rcd_d;
      rp_q   <= rp_d;
      wr_q   <= wr_d;
      ras_q  <= ras_d;
      rc_q   <= rc_d;
    end
  end

  assign is_open = open_q;
  assign rcd_ok  = (rcd_q == '0);
  assign rp_ok   = (rp_q == '0);
  assign wr_ok   = (wr_q == '0);
  assign ras_ok  = (ras_q == '0);
  assign rc_ok   = (rc_q == '0);

endmodule

// File: rtl/ddr_bank_checker.sv
module ddr_bank_checker
  import ddr_chk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_RP  = 3,
  parameter int T_WR  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       a10,
  output logic [2:0] cmd_code,
  output logic [7:0] err_flags
);

  localparam int BA_W  = 2;
  localparam int NBANK = 1 << BA_W;
  localparam int M1    = (T_RCD > T_RRD) ? T_RCD : T_RRD;
  localparam int M2    = (T_RP > T_WR) ? T_RP : T_WR;
  localparam int M3    = (T_RAS > T_RC) ? T_RAS : T_RC;
  localparam int M12   = (M1 > M2) ? M1 : M2;
  localparam int T_MAX = (M12 > M3) ? M12 : M3;
  localparam int CW    = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] LD_RRD = CW'(T_RRD - 1);

  logic rst_q_n;

  ddr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cmd_e cmd_d;

  ddr_cmd_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd_d)
  );

  logic act_i, rd_i, wr_i, pre_i, rw_i;
  assign act_i = (cmd_d == CMD_ACT);
  assign rd_i  = (cmd_d == CMD_RD);
  assign wr_i  = (cmd_d == CMD_WR);
  assign pre_i = (cmd_d == CMD_PRE);
  assign rw_i  = rd_i | wr_i;

  logic [NBANK-1:0] sel_v, pre_mask;
  logic [NBANK-1:0] open_v, rcd_ok_v, ras_ok_v, rc_ok_v, rp_ok_v, wr_ok_v;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign sel_v[g]    = (ba == BA_W'(g));
    assign pre_mask[g] = pre_i & (a10 | sel_v[g]);

    ddr_bank_track #(
      .T_RCD (T_RCD),
      .T_RP  (T_RP),
      .T_WR  (T_WR),
      .T_RAS (T_RAS),
      .T_RC  (T_RC),
      .CW    (CW)
    ) u_track (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .act_hit (act_i & sel_v[g]),
      .wr_hit  (wr_i & sel_v[g]),
      .pre_hit (pre_mask[g]),
      .is_open (open_v[g]),
      .rcd_ok  (rcd_ok_v[g]),
      .ras_ok  (ras_ok_v[g]),
      .rc_ok   (rc_ok_v[g]),
      .rp_ok   (rp_ok_v[g]),
      .wr_ok   (wr_ok_v[g])
    );
  end

  // cross-bank activate spacing
  logic [CW-1:0]   rrd_q, rrd_d;
  logic [BA_W-1:0] last_ba_q, last_ba_d;

  always_comb begin
    rrd_d     = (rrd_q == '0) ? '0 : rrd_q - 1'b1;
    last_ba_d = last_ba_q;
    if (act_i) begin
      rrd_d     = LD_RRD;
      last_ba_d = ba;
    end
  end

  // violation detection on the current command
  logic [ERR_W-1:0] err_new;
  logic [ERR_W-1:0] err_q, err_d;
  logic             err_en;
  cmd_e             cmd_q;

  always_comb begin
    err_new             = '0;
    err_new[E_ACT_OPEN] = act_i & open_v[ba];
    err_new[E_RP]       = act_i & ~rp_ok_v[ba];
    err_new[E_RC]       = act_i & ~rc_ok_v[ba];
    err_new[E_RRD]      = act_i & (rrd_q != '0) & (ba != last_ba_q);
    err_new[E_RW_SHUT]  = rw_i & ~open_v[ba];
    err_new[E_RCD]      = rw_i & open_v[ba] & ~rcd_ok_v[ba];
    err_new[E_RAS]      = |(pre_mask & open_v & ~ras_ok_v);
    err_new[E_WR]       = |(pre_mask & open_v & ~wr_ok_v);
    err_en              = |err_new;
    err_d               = err_q | err_new;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cmd_q     <= CMD_DES;
      rrd_q     <= '0;
      last_ba_q <= '0;
    end else begin
      cmd_q     <= cmd_d;
      rrd_q     <= rrd_d;
      last_ba_q <= last_ba_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      err_q <= '0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign cmd_code  = cmd_q;
  assign err_flags = err_q;

endmodule

// File: rtl/ddr_bank_checker_sva.sv
module ddr_bank_checker_sva #(
  parameter int T_RCD = 3
) (
  input logic       clk,
  input logic       rst_q_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       a10,
  input logic [2:0] cmd_code,
  input logic [7:0] err_flags
);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) seen_q <= 1'b0;
    else          seen_q <= 1'b1;
  end

  logic act_in, rw_in, pre_in, nop_in;
  assign act_in = !cs_n && !ras_n && cas_n && we_n;
  assign rw_in  = !cs_n && ras_n && !cas_n;
  assign pre_in = !cs_n && !ras_n && cas_n && !we_n;
  assign nop_in = !cs_n && ras_n && cas_n && we_n;

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    seen_q |-> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    cs_n |=> (cmd_code == 3'd0 && err_flags == $past(err_flags)));

  assert_nop_code_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    nop_in |=> (cmd_code == 3'd1 && err_flags == $past(err_flags)));

  assert_act_open_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (seen_q && act_in && $past(act_in) && ba == $past(ba)) |=> err_flags[0]);

  assert_trcd_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((T_RCD > 1) && seen_q && rw_in && $past(act_in) && ba == $past(ba)) |=> err_flags[2]);

  assert_closed_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (seen_q && rw_in && $past(pre_in && a10)) |=> err_flags[1]);

endmodule

bind ddr_bank_checker ddr_bank_checker_sva #(.T_RCD(T_RCD)) u_sva (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .a10       (a10),
  .cmd_code  (cmd_code),
  .err_flags (err_flags)
);

// File: tb/tb_ddr_bank_checker.sv
module tb_ddr_bank_checker;

  localparam int T_RCD = 3;
  localparam int T_RRD = 2;
  localparam int T_RP  = 3;
  localparam int T_WR  = 3;
  localparam int T_RAS = 6;
  localparam int T_RC  = 9;
  localparam int FAR   = -1000;

  logic       clk;
  logic       rst_n;
  logic       cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic       a10;
  logic [2:0] cmd_code;
  logic [7:0] err_flags;

  int checks;
  int failures;

  ddr_bank_checker #(
    .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RP(T_RP),
    .T_WR(T_WR), .T_RAS(T_RAS), .T_RC(T_RC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cmd_code(cmd_code), .err_flags(err_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // timestamp model
  int   now;
  int   t_act[4];
  int   t_pre[4];
  int   t_wr[4];
  bit   opn[4];
  int   t_act_any;
  int   ba_act_any;
  bit   any_act;
  logic [7:0] exp_err;

  function automatic string req_of(input int i);
    case (i)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_clear();
    now = 0;
    for (int b = 0; b < 4; b++) begin
      t_act[b] = FAR; t_pre[b] = FAR; t_wr[b] = FAR; opn[b] = 1'b0;
    end
    t_act_any = FAR; ba_act_any = 0; any_act = 1'b0;
    exp_err = '0;
  endtask

  function automatic logic [2:0] exp_code(input logic c, r, ca, w);
    if (c) return 3'd0;
    case ({r, ca, w})
      3'b111: return 3'd1;
      3'b011: return 3'd2;
      3'b101: return 3'd3;
      3'b100: return 3'd4;
      3'b010: return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  task automatic model_step(input logic [2:0] code, input int b, input logic a);
    now++;
    case (code)
      3'd2: begin
        if (opn[b]) exp_err[0] = 1'b1;
        if (now - t_pre[b] < T_RP) exp_err[4] = 1'b1;
        if (now - t_act[b] < T_RC) exp_err[6] = 1'b1;
        if (any_act && ba_act_any != b && now - t_act_any < T_RRD) exp_err[3] = 1'b1;
        opn[b] = 1'b1; t_act[b] = now; t_act_any = now; ba_act_any = b; any_act = 1'b1;
      end
      3'd3, 3'd4: begin
        if (!opn[b]) exp_err[1] = 1'b1;
        else begin
          if (now - t_act[b] < T_RCD) exp_err[2] = 1'b1;
          if (code == 3'd4) t_wr[b] = now;
        end
      end
      3'd5: begin
        for (int k = 0; k < 4; k++) begin
          if ((a || k == b) && opn[k]) begin
            if (now - t_act[k] < T_RAS) exp_err[5] = 1'b1;
            if (now - t_wr[k] < T_WR) exp_err[7] = 1'b1;
            opn[k] = 1'b0; t_pre[k] = now;
          end
        end
      end
      default: ;
    endcase
  endtask

  task automatic issue(input logic c, r, ca, w, input logic [1:0] b, input logic a);
    logic [2:0] ec;
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
    @(posedge clk);
    ec = exp_code(c, r, ca, w);
    model_step(ec, int'(b), a);
    #1;
    checks++;
    if (cmd_code !== ec) begin
      failures++;
      $display("FAIL %s code: got %0d expected %0d", c ? "R2" : "R1", cmd_code, ec);
    end
    checks++;
    if (err_flags !== exp_err) begin
      failures++;
      for (int i = 0; i < 8; i++)
        if (err_flags[i] !== exp_err[i])
          $display("FAIL %s flag bit %0d: got %0b expected %0b (vector %b vs %b)",
                   req_of(i), i, err_flags[i], exp_err[i], err_flags, exp_err);
    end
  endtask

  task automatic des();                        issue(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0); endtask
  task automatic nop(input int n);             for (int i = 0; i < n; i++) issue(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0); endtask
  task automatic act(input logic [1:0] b);     issue(1'b0, 1'b0, 1'b1, 1'b1, b, 1'b0); endtask
  task automatic rd(input logic [1:0] b);      issue(1'b0, 1'b1, 1'b0, 1'b1, b, 1'b0); endtask
  task automatic wr(input logic [1:0] b);      issue(1'b0, 1'b1, 1'b0, 1'b0, b, 1'b0); endtask
  task automatic pre(input logic [1:0] b, input logic a); issue(1'b0, 1'b0, 1'b1, 1'b0, b, a); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = 2'd0; a10 = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    model_clear();
    checks++;
    if (cmd_code !== 3'd0 || err_flags !== 8'd0) begin
      failures++;
      $display("FAIL R13 reset state: got code %0d flags %b expected 0 and 00000000", cmd_code, err_flags);
    end
  endtask

  bit done;

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = 2'd0; a10 = 1'b0;
    model_clear();

    // R1, R2: every control pattern, deselect mixed with random-like bank bits
    do_reset();
    for (int v = 0; v < 64; v++) begin
      issue(v[3], v[2], v[1], v[0], v[5:4], v[4]);
      des();
    end

    // R2: a deselected activate pattern must not open the bank
    do_reset();
    issue(1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0);
    nop(T_RCD);
    rd(2'd2);
    checks++;
    if (err_flags[1] !== 1'b1) begin
      failures++; $display("FAIL R2 ignored activate: got %0b expected 1", err_flags[1]);
    end

    // R6: activate-to-column gap sweep, read and write, each bank
    for (int b = 0; b < 4; b++)
      for (int g = 1; g <= T_RCD + 1; g++)
        for (int w = 0; w < 2; w++) begin
          do_reset();
          act(2'(b)); nop(g - 1);
          if (w == 1) wr(2'(b)); else rd(2'(b));
        end

    // R7: cross-bank activate gap sweep, plus same bank pair (R4/R10)
    for (int b0 = 0; b0 < 4; b0++)
      for (int b1 = 0; b1 < 4; b1++)
        for (int g = 1; g <= T_RRD + 1; g++) begin
          do_reset();
          act(2'(b0)); nop(g - 1); act(2'(b1));
        end

    // R9: activate-to-precharge gap sweep, single and all-bank
    for (int g = 1; g <= T_RAS + 1; g++)
      for (int a = 0; a < 2; a++) begin
        do_reset();
        act(2'd1); nop(g - 1); pre(2'd1, 1'(a));
      end

    // R8, R10: precharge-to-activate and activate-to-activate sweeps
    for (int h = T_RAS; h <= T_RAS + 3; h++)
      for (int g = 1; g <= T_RP + 2; g++)
        for (int a = 0; a < 2; a++) begin
          do_reset();
          act(2'd3); nop(h - 1); pre(2'd3, 1'(a)); nop(g - 1); act(2'd3);
        end

    // R11: write-to-precharge gap sweep
    for (int g = 1; g <= T_WR + 1; g++)
      for (int a = 0; a < 2; a++) begin
        do_reset();
        act(2'd0); nop(T_RAS + 1); wr(2'd0); nop(g - 1); pre(2'd0, 1'(a));
      end

    // R3: single-bank precharge leaves others open; all-bank closes the rest
    do_reset();
    for (int b = 0; b < 4; b++) begin act(2'(b)); nop(T_RRD - 1); end
    nop(T_RC);
    pre(2'd2, 1'b0);
    for (int b = 0; b < 4; b++) if (b != 2) rd(2'(b));
    checks++;
    if (err_flags !== 8'd0) begin
      failures++; $display("FAIL R3 single precharge: got %b expected 00000000", err_flags);
    end
    pre(2'd0, 1'b1);
    nop(T_RP);
    pre(2'd1, 1'b0);
    act(2'd1);
    checks++;
    if (err_flags !== 8'd0) begin
      failures++; $display("FAIL R3 precharge of closed bank: got %b expected 00000000", err_flags);
    end
    for (int b = 0; b < 4; b++) if (b != 1) rd(2'(b));

    // R4, R12: reopen error, flag held through idle time, state still updated
    do_reset();
    act(2'd0); nop(T_RC); act(2'd0); nop(40);
    checks++;
    if (err_flags[0] !== 1'b1) begin
      failures++; $display("FAIL R12 sticky: got %0b expected 1", err_flags[0]);
    end
    rd(2'd0);
    nop(2);
    rd(2'd3);

    // R13: mid-run reset clears flags
    do_reset();
    nop(3);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got hung run expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule